// File: doc/BRIEF.md
# Counter-Compare PWM Channel

This block is one compare channel attached to a free-running timebase counter. It turns a programmed compare value into a pulse-width-modulated output. In the wide mode the channel compares against the whole timebase. In the three narrow modes it compares against only the low N bits, where N is `SHORT_BASE`, `SHORT_BASE+1` or `SHORT_BASE+2`. In both cases the compare value is the count of low-time ticks in each period. The output rises when the counter equals the compare value and falls when the counter wraps. The high time per period is therefore the period length minus the compare value.

Software reaches the channel through a byte-wide write port. The compare value is written as a low byte and then a high byte. Each byte write also has a side effect on the compare-enable bit. A mode byte and a control byte select the operating mode. A flag-clear byte clears the sticky match and wrap flags. In the narrow modes, a select bit redirects the compare byte writes to a shadow reload register. The channel copies that register into the live compare register at each narrow wrap, so a duty change never cuts a period short.

Top module: `pwm_channel`

## Requirements
- R1: A synchronous active-high reset clears the timebase, all registers, the output and both flags. After reset, `pwm_out`, `match_flag` and `ovf_flag` read 0.
- R2: The channel is active only under two conditions. The first is mode bits ecom (bit 0), pwm_en (bit 1) and wide (bit 2) all set. The second is ecom and pwm_en set, wide clear and a nonzero width select. While inactive, `pwm_out` is held at 0.
- R3: In the wide mode with compare value C, `pwm_out` is high for exactly 2^CNT_W − C cycles of every 2^CNT_W-cycle period, as one contiguous pulse. C = 0 gives a constant high. C = all ones gives a one-cycle pulse.
- R4: With ecom clear, `pwm_out` stays 0 (0% duty) for any compare value.
- R5: A write to address 0 (compare low byte) loads compare bits [7:0] and clears ecom. A write to address 1 (compare high byte) loads bits [CNT_W-1:8] and sets ecom. This applies only while the reload-select bit is clear.
- R6: When mode bit 3 (match enable) is set, `match_flag` is set by every compare match of an active channel. When that bit is clear, no match sets the flag.
- R7: `ovf_flag` is set whenever the active width of the timebase wraps from all ones to zero.
- R8: Both flags stay set until a write to address 4. Data bit 0 of that write clears `ovf_flag` and data bit 1 clears `match_flag`. If a set and a clear fall in the same cycle, the set wins.
- R9: In the narrow mode, control bits [1:0] select the width: 1 gives SHORT_BASE bits, 2 gives SHORT_BASE+1 bits and 3 gives SHORT_BASE+2 bits. The period is 2^N and the high time is 2^N − (C mod 2^N).
- R10: With control bit 2 (reload select) set, writes to addresses 0 and 1 go to the reload register and leave ecom unchanged. In the narrow mode, the reload value is copied into the compare register at each N-bit wrap.
- R11: While `run` is low, the timebase, the output and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Timebase advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 compare/reload low, 1 compare/reload high, 2 mode, 3 control, 4 flag clear |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 1 | Registered PWM output |
| match_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky timebase-wrap flag |

## Verification
The bench builds the channel with CNT_W = 12 and the default SHORT_BASE = 9. This keeps a wide period at 4096 cycles. Full-period duty measurements then fit in the run for the wide compare extremes 0 and 0xFFF as well as mid values. It also leaves the narrow 9-, 10- and 11-bit widths distinct from the wide width. With those parameters, the reload path, the masking of compare bits above N and the byte side effects on ecom can all be exercised over complete periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [2:0] {
    A_CMP_LO = 3'd0,
    A_CMP_HI = 3'd1,
    A_MODE   = 3'd2,
    A_CTL    = 3'd3,
    A_FCLR   = 3'd4
  } pwm_addr_e;

  // mode byte, bits [3:0]
  typedef struct packed {
    logic mat_en;
    logic wide;
    logic pwm_en;
    logic ecom;
  } pwm_mode_t;

  // control byte, bits [2:0]
  typedef struct packed {
    logic       arsel;
    logic [1:0] nsel;
  } pwm_ctl_t;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             reload_evt,
  output logic [CNT_W-1:0] cmp,
  output pwm_mode_t        mode,
  output pwm_ctl_t         ctl,
  output logic             clr_ovf,
  output logic             clr_match
);

  localparam int HI_W = CNT_W - 8;

  logic [CNT_W-1:0] rld;
  logic lo_wr, hi_wr, mode_wr, ctl_wr, fclr_wr;

  always_comb begin
    lo_wr     = wr_en && (wr_addr == A_CMP_LO);
    hi_wr     = wr_en && (wr_addr == A_CMP_HI);
    mode_wr   = wr_en && (wr_addr == A_MODE);
    ctl_wr    = wr_en && (wr_addr == A_CTL);
    fclr_wr   = wr_en && (wr_addr == A_FCLR);
    clr_ovf   = fclr_wr && wr_data[0];
    clr_match = fclr_wr && wr_data[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp  <= '0;
      rld  <= '0;
      mode <= '0;
      ctl  <= '0;
    end else begin
      // narrow-mode wrap: shadow value becomes live
      if (reload_evt) cmp <= rld;
      if (lo_wr) begin
        if (ctl.arsel) rld[7:0] <= wr_data;
        else begin
          cmp[7:0]  <= wr_data;
          mode.ecom <= 1'b0;
        end
      end
      if (hi_wr) begin
        if (ctl.arsel) rld[CNT_W-1:8] <= wr_data[HI_W-1:0];
        else begin
          cmp[CNT_W-1:8] <= wr_data[HI_W-1:0];
          mode.ecom      <= 1'b1;
        end
      end
      if (mode_wr) mode <= pwm_mode_t'(wr_data[3:0]);
      if (ctl_wr)  ctl  <= pwm_ctl_t'(wr_data[2:0]);
    end
  end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SHORT_BASE = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  pwm_mode_t        mode,
  input  pwm_ctl_t         ctl,
  input  logic             clr_ovf,
  input  logic             clr_match,
  output logic             reload_evt,
  output logic             pwm_out,
  output logic             match_flag,
  output logic             ovf_flag
);

  localparam logic [CNT_W-1:0] FULL_M = '1;
  localparam logic [CNT_W-1:0] MASK_1 = FULL_M >> (CNT_W - SHORT_BASE);
  localparam logic [CNT_W-1:0] MASK_2 = FULL_M >> (CNT_W - SHORT_BASE - 1);
  localparam logic [CNT_W-1:0] MASK_3 = FULL_M >> (CNT_W - SHORT_BASE - 2);

  logic             narrow, active, hit, at_zero, at_top;
  logic [CNT_W-1:0] mask;

  always_comb begin
    narrow = !mode.wide && (ctl.nsel != 2'd0);
    active = mode.ecom && mode.pwm_en && (mode.wide || narrow);
    mask   = FULL_M;
    if (narrow) begin
      case (ctl.nsel)
        2'd1:    mask = MASK_1;
        2'd2:    mask = MASK_2;
        default: mask = MASK_3;
      endcase
    end
    hit        = (cnt & mask) == (cmp & mask);
    at_zero    = (cnt & mask) == '0;
    at_top     = (cnt & mask) == mask;
    reload_evt = run && narrow && at_top;
  end

  // output level for count c+1 is decided from count c
  always_ff @(posedge clk) begin
    if (rst)                pwm_out <= 1'b0;
    else if (!active)       pwm_out <= 1'b0;
    else if (run) begin
      if (hit)              pwm_out <= 1'b1;
      else if (at_zero)     pwm_out <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_flag <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      if (run && active && hit && mode.mat_en) match_flag <= 1'b1;
      else if (clr_match)                      match_flag <= 1'b0;
      if (run && at_top)                       ovf_flag   <= 1'b1;
      else if (clr_ovf)                        ovf_flag   <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SHORT_BASE = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pwm_out,
  output logic       match_flag,
  output logic       ovf_flag
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  pwm_mode_t        mode;
  pwm_ctl_t         ctl;
  logic             clr_ovf, clr_match, reload_evt;
  logic             ecom, arsel, mat_en;

  assign ecom   = mode.ecom;
  assign arsel  = ctl.arsel;
  assign mat_en = mode.mat_en;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk (clk),
    .rst (rst),
    .run (run),
    .cnt (cnt)
  );

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .reload_evt (reload_evt),
    .cmp        (cmp),
    .mode       (mode),
    .ctl        (ctl),
    .clr_ovf    (clr_ovf),
    .clr_match  (clr_match)
  );

  pwm_compare #(.CNT_W(CNT_W), .SHORT_BASE(SHORT_BASE)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .cnt        (cnt),
    .cmp        (cmp),
    .mode       (mode),
    .ctl        (ctl),
    .clr_ovf    (clr_ovf),
    .clr_match  (clr_match),
    .reload_evt (reload_evt),
    .pwm_out    (pwm_out),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag)
  );

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             pwm_out,
  input logic             match_flag,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] cnt,
  input logic             ecom,
  input logic             arsel,
  input logic             mat_en
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pwm_out && !match_flag && !ovf_flag));

  a_r4_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !ecom |=> !pwm_out);

  a_r5_low_byte_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0 && !arsel) |=> !ecom);

  a_r5_high_byte_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd1 && !arsel) |=> ecom);

  a_r10_reload_keeps_enable: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1) && arsel) |=> (ecom == $past(ecom)));

  a_r6_match_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(match_flag) |-> $past(mat_en));

  a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == '1) |=> ovf_flag);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> ovf_flag);

  a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

endmodule

bind pwm_channel pwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run        (run),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .pwm_out    (pwm_out),
  .match_flag (match_flag),
  .ovf_flag   (ovf_flag),
  .cnt        (cnt),
  .ecom       (ecom),
  .arsel      (arsel),
  .mat_en     (mat_en)
);

// File: tb/test_pwm_channel.sv
module test_pwm_channel;

  localparam int CNT_W      = 12;
  localparam int SHORT_BASE = 9;
  localparam int WIDE_P     = 1 << CNT_W;
  localparam int NVEC       = 9;

  // {wide, nsel[1:0], compare[15:0]}
  localparam logic [18:0] VEC [0:NVEC-1] = '{
    {1'b1, 2'd0, 16'h0000},
    {1'b1, 2'd0, 16'h0FFF},
    {1'b1, 2'd0, 16'h0001},
    {1'b1, 2'd0, 16'h0800},
    {1'b1, 2'd0, 16'h09C4},
    {1'b0, 2'd1, 16'h01FF},
    {1'b0, 2'd2, 16'h0155},
    {1'b0, 2'd3, 16'h0000},
    {1'b0, 2'd1, 16'h07F3}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out, match_flag, ovf_flag;

  int n_checks = 0;
  int n_fails  = 0;
  int hi_cnt, rise_cnt;

  always #10 clk = ~clk;

  pwm_channel #(.CNT_W(CNT_W), .SHORT_BASE(SHORT_BASE)) i_pwm_channel (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pwm_out    (pwm_out),
    .match_flag (match_flag),
    .ovf_flag   (ovf_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts high cycles and rising edges over p consecutive cycles
  task automatic measure(input int p);
    logic prev;
    @(negedge clk);
    prev     = pwm_out;
    hi_cnt   = 0;
    rise_cnt = 0;
    for (int k = 0; k < p; k++) begin
      @(negedge clk);
      if (pwm_out) hi_cnt++;
      if (pwm_out && !prev) rise_cnt++;
      prev = pwm_out;
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    check("R1 pwm_out", pwm_out, 0);
    check("R1 match_flag", match_flag, 0);
    check("R1 ovf_flag", ovf_flag, 0);
    run = 1'b1;

    // table walk: R3 wide duty, R9/R10 narrow duty via reload
    for (int i = 0; i < NVEC; i++) begin
      logic        wide;
      logic [1:0]  nsel;
      logic [15:0] c;
      int          nb, p, cm;
      wide = VEC[i][18];
      nsel = VEC[i][17:16];
      c    = VEC[i][15:0];
      if (wide) begin
        wr(3'd2, 8'h06);
        wr(3'd3, 8'h00);
        wr(3'd0, c[7:0]);
        wr(3'd1, c[15:8]);
        nb = CNT_W;
      end else begin
        wr(3'd3, {5'd0, 1'b1, nsel});
        wr(3'd0, c[7:0]);
        wr(3'd1, c[15:8]);
        wr(3'd2, 8'h03);
        nb = SHORT_BASE + int'(nsel) - 1;
      end
      p  = 1 << nb;
      cm = int'(c) & (p - 1);
      idle(p + 8);
      measure(p);
      check(wide ? "R3 high cycles" : "R9 R10 high cycles", hi_cnt, p - cm);
      check(wide ? "R3 pulse count" : "R9 pulse count", rise_cnt, (cm == 0) ? 0 : 1);
    end

    // R2: pwm_en clear in wide mode -> no output
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h04);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    idle(8);
    measure(WIDE_P);
    check("R2 pwm_en clear", hi_cnt, 0);
    // R2: narrow with width select 0 -> inactive
    wr(3'd2, 8'h03);
    idle(8);
    measure(WIDE_P);
    check("R2 width select zero", hi_cnt, 0);

    // R5: byte side effects on ecom
    wr(3'd2, 8'h06);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h04);
    idle(WIDE_P + 8);
    measure(WIDE_P);
    check("R5 high byte enables", hi_cnt, WIDE_P - 'h400);
    wr(3'd0, 8'h20);
    idle(8);
    measure(WIDE_P);
    check("R5 low byte disables", hi_cnt, 0);
    wr(3'd1, 8'h04);
    idle(WIDE_P + 8);
    measure(WIDE_P);
    check("R5 high byte re-enables", hi_cnt, WIDE_P - 'h420);

    // R4: ecom cleared through the mode byte
    wr(3'd2, 8'h06);
    idle(8);
    measure(WIDE_P);
    check("R4 zero duty", hi_cnt, 0);

    // R6/R7: match enable off, then on
    wr(3'd2, 8'h07);
    wr(3'd4, 8'h03);
    idle(WIDE_P + 8);
    check("R6 match disabled", match_flag, 0);
    check("R7 wrap flag", ovf_flag, 1);
    wr(3'd2, 8'h0F);
    wr(3'd4, 8'h03);
    idle(WIDE_P + 8);
    check("R6 match enabled", match_flag, 1);

    // R8/R11: freeze, flags stick, selective clears, output holds
    run = 1'b0;
    idle(2);
    begin
      logic held;
      int   changes;
      held    = pwm_out;
      changes = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (pwm_out != held) changes++;
      end
      check("R11 output frozen", changes, 0);
    end
    check("R8 ovf sticky", ovf_flag, 1);
    check("R8 match sticky", match_flag, 1);
    wr(3'd4, 8'h01);
    check("R8 ovf cleared", ovf_flag, 0);
    check("R8 match kept", match_flag, 1);
    wr(3'd4, 8'h02);
    check("R8 match cleared", match_flag, 0);
    idle(50);
    check("R11 flags frozen", ovf_flag, 0);
    run = 1'b1;

    // R10: reload writes leave ecom alone, then take effect at wrap
    wr(3'd3, 8'h05);
    wr(3'd2, 8'h02);
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h00);
    idle(8);
    measure(1 << SHORT_BASE);
    check("R10 ecom untouched", hi_cnt, 0);
    wr(3'd2, 8'h03);
    idle((1 << SHORT_BASE) + 8);
    measure(1 << SHORT_BASE);
    check("R10 reload duty", hi_cnt, (1 << SHORT_BASE) - 'h10);

    finish_run();
  end

endmodule